// File: doc/BRIEF.md
# Multiplexed General-Purpose Pin Port

This block runs a bank of bidirectional pins, 16 by default. Each pin is set up on its own. It can be a software-driven input, a software-driven output, an input for an on-chip peripheral, or an output driven by that peripheral. Software reaches four registers through a simple bus with a write strobe: pin assignment, direction, open-drain enable and data. The block drives an output enable and an output value to each pad. Every pad level passes through a two-stage synchronizer. The synchronized level then goes to the peripheral input and to the data-register read path.

A pin's assignment bit and its direction bit together set its role. Any pin can be switched to open-drain. In that mode the pin pulls low and releases the pad for a high. The data latch can always be written, whatever the pin's role. Its contents reach the pad only while the pin is a general-purpose output.

Top module: `gpio_mux_port`

## Requirements
- R1: A synchronous reset, with rst_n low at a clock edge, clears the assignment, direction, open-drain and data-latch registers. After reset every pad_oe bit is 0, and reads at offsets 0x0, 0x4 and 0x8 return 0.
- R2: The registers sit at these offsets: assignment at 0x0, direction at 0x4, open-drain at 0x8 and data at 0xC. A write with bus_we high takes effect at the next rising clock edge. Reads are combinational on bus_addr. Any other offset ignores writes and reads as 0.
- R3: A pin with assignment bit 0 and direction bit 0 is a general-purpose input, and its pad_oe is 0.
- R4: A pin with assignment bit 0, direction bit 1 and open-drain bit 0 drives pad_oe=1 and pad_out equal to its latch bit.
- R5: In open-drain mode a general-purpose output with latch bit 0 drives pad_oe=1 and pad_out=0. With latch bit 1 it drives pad_oe=0. An open-drain pin never drives pad_out=1.
- R6: A pin with assignment bit 1 and direction bit 1 belongs to the peripheral. It takes pad_oe from per_oe and pad_out from per_out, ANDed with per_oe. The latch has no effect on such a pin.
- R7: A peripheral-owned pin in open-drain mode drives pad_oe = per_oe AND NOT per_out, and pad_out=0.
- R8: A pin with assignment bit 1 and direction bit 0 is a peripheral input, and its pad_oe is 0 whatever per_oe is.
- R9: per_in equals pad_in as it was two rising edges earlier. A change on pad_in is not visible after only one edge.
- R10: A read at offset 0xC returns the synchronized pad level, never the latch contents. This holds in every pin mode.
- R11: A latch value written while a pin belongs to the peripheral is driven once the pin becomes a general-purpose output.
- R12: Each pin follows only its own bits. A mixed configuration gives each pin the result its own mode calls for. This holds even when the configuration write and a change on per_out happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| pad_in | input | 16 | Level seen at each pad |
| pad_oe | output | 16 | Pad driver enable per pin |
| pad_out | output | 16 | Pad drive value per pin |
| per_out | input | 16 | Peripheral output value per pin |
| per_oe | input | 16 | Peripheral output enable per pin |
| per_in | output | 16 | Synchronized pad level to the peripheral |

## Verification
A register write that changes a pin's role can land in the same cycle as a change on the peripheral's drive. The pad outputs must then reflect the new mode and the new peripheral value together, with no stale mix of the two. The bench provokes this by raising the assignment-register write strobe on the same clock low phase in which it changes per_out. At the following low phase it compares pad_oe and pad_out, pin by pin, against the results worked out from the mixed configuration. A second overlap is a data-register write while that register is being read. The read must keep returning the synchronized pad level and not the value just written.

// File: rtl/gpio_mux_pkg.sv
// Package: shared offsets and pin-role encoding for the multiplexed pin port.
// Assumes byte offsets fit in the bus address width used by the top.
package gpio_mux_pkg;

    localparam int unsigned OFF_ASSIGN = 32'h0;
    localparam int unsigned OFF_DIR    = 32'h4;
    localparam int unsigned OFF_ODRAIN = 32'h8;
    localparam int unsigned OFF_DATA   = 32'hC;

    // Role of a pin, encoded as {assignment bit, direction bit}.
    typedef enum logic [1:0] {
        ROLE_SW_IN   = 2'b00,
        ROLE_SW_OUT  = 2'b01,
        ROLE_PER_IN  = 2'b10,
        ROLE_PER_OUT = 2'b11
    } pin_role_e;

endpackage

// File: rtl/gpio_sync2.sv
// Module: two-stage synchronizer for a vector of asynchronous pad levels.
// Assumes each bit is independent; no multi-bit coherence is promised.
module gpio_sync2 #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_d,
    output logic [WIDTH-1:0] sync_q
);

    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    // Shift pad levels through two flops; clear both on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= async_d;
            stage2 <= stage1;
        end
    end

    assign sync_q = stage2;

endmodule

// File: rtl/gpio_regfile.sv
// Module: configuration and data registers behind a simple write-strobe bus.
// Assumes full-address decode; unmapped offsets drop writes and read zero.
// The data offset reads back the synchronized pad level, not the latch.
module gpio_regfile
    import gpio_mux_pkg::*;
#(
    parameter int unsigned PINS   = 16,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    input  logic [PINS-1:0]   pad_sync,
    output logic [PINS-1:0]   bus_rdata,
    output logic [PINS-1:0]   assign_q,
    output logic [PINS-1:0]   dir_q,
    output logic [PINS-1:0]   odrain_q,
    output logic [PINS-1:0]   latch_q
);

    localparam logic [ADDR_W-1:0] A_ASSIGN = ADDR_W'(OFF_ASSIGN);
    localparam logic [ADDR_W-1:0] A_DIR    = ADDR_W'(OFF_DIR);
    localparam logic [ADDR_W-1:0] A_ODRAIN = ADDR_W'(OFF_ODRAIN);
    localparam logic [ADDR_W-1:0] A_DATA   = ADDR_W'(OFF_DATA);

    // Update the addressed register on a write strobe; clear all on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            assign_q <= '0;
            dir_q    <= '0;
            odrain_q <= '0;
            latch_q  <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                A_ASSIGN: assign_q <= bus_wdata;
                A_DIR:    dir_q    <= bus_wdata;
                A_ODRAIN: odrain_q <= bus_wdata;
                A_DATA:   latch_q  <= bus_wdata;
                default:  ;
            endcase
        end
    end

    // Select read data by offset; the data offset shows pad levels.
    always_comb begin
        case (bus_addr)
            A_ASSIGN: bus_rdata = assign_q;
            A_DIR:    bus_rdata = dir_q;
            A_ODRAIN: bus_rdata = odrain_q;
            A_DATA:   bus_rdata = pad_sync;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_pin_cell.sv
// Module: drive logic for one pin; picks the source from the pin role and
// applies open-drain emulation. Assumes pad_out is a don't-care when
// pad_oe is low, and forces it to 0 there for a clean pad interface.
module gpio_pin_cell
    import gpio_mux_pkg::*;
(
    input  logic assign_b,
    input  logic dir_b,
    input  logic odrain_b,
    input  logic latch_b,
    input  logic per_out_b,
    input  logic per_oe_b,
    output logic pad_oe_b,
    output logic pad_out_b
);

    pin_role_e role;
    logic      want_oe;
    logic      want_val;

    assign role = pin_role_e'({assign_b, dir_b});

    // Choose the drive request and value from the pin role.
    always_comb begin
        case (role)
            ROLE_SW_OUT: begin
                want_oe  = 1'b1;
                want_val = latch_b;
            end
            ROLE_PER_OUT: begin
                want_oe  = per_oe_b;
                want_val = per_out_b;
            end
            default: begin
                want_oe  = 1'b0;
                want_val = 1'b0;
            end
        endcase
    end

    // Apply open-drain: drive only a low, release the pad for a high.
    always_comb begin
        if (odrain_b) begin
            pad_oe_b  = want_oe & ~want_val;
            pad_out_b = 1'b0;
        end else begin
            pad_oe_b  = want_oe;
            pad_out_b = want_oe & want_val;
        end
    end

endmodule

// File: rtl/gpio_pad_mux.sv
// Module: one drive cell per pin, replicated across the port.
// Assumes all vectors share the PINS width.
module gpio_pad_mux #(
    parameter int unsigned PINS = 16
) (
    input  logic [PINS-1:0] assign_q,
    input  logic [PINS-1:0] dir_q,
    input  logic [PINS-1:0] odrain_q,
    input  logic [PINS-1:0] latch_q,
    input  logic [PINS-1:0] per_out,
    input  logic [PINS-1:0] per_oe,
    output logic [PINS-1:0] pad_oe,
    output logic [PINS-1:0] pad_out
);

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        gpio_pin_cell u_cell (
            .assign_b  (assign_q[p]),
            .dir_b     (dir_q[p]),
            .odrain_b  (odrain_q[p]),
            .latch_b   (latch_q[p]),
            .per_out_b (per_out[p]),
            .per_oe_b  (per_oe[p]),
            .pad_oe_b  (pad_oe[p]),
            .pad_out_b (pad_out[p])
        );
    end

endmodule

// File: rtl/gpio_mux_port.sv
// Module: top of the multiplexed pin port. It joins the register file, the
// pad synchronizer and the per-pin drive mux. Assumes a single clock
// domain for the bus and the peripheral; pad_in is asynchronous.
module gpio_mux_port #(
    parameter int unsigned PINS   = 16,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_oe,
    output logic [PINS-1:0]   pad_out,
    input  logic [PINS-1:0]   per_out,
    input  logic [PINS-1:0]   per_oe,
    output logic [PINS-1:0]   per_in
);

    logic [PINS-1:0] pad_sync;
    logic [PINS-1:0] assign_q;
    logic [PINS-1:0] dir_q;
    logic [PINS-1:0] odrain_q;
    logic [PINS-1:0] latch_q;

    gpio_sync2 #(.WIDTH(PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_d (pad_in),
        .sync_q  (pad_sync)
    );

    gpio_regfile #(.PINS(PINS), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pad_sync  (pad_sync),
        .bus_rdata (bus_rdata),
        .assign_q  (assign_q),
        .dir_q     (dir_q),
        .odrain_q  (odrain_q),
        .latch_q   (latch_q)
    );

    gpio_pad_mux #(.PINS(PINS)) u_mux (
        .assign_q (assign_q),
        .dir_q    (dir_q),
        .odrain_q (odrain_q),
        .latch_q  (latch_q),
        .per_out  (per_out),
        .per_oe   (per_oe),
        .pad_oe   (pad_oe),
        .pad_out  (pad_out)
    );

    assign per_in = pad_sync;

endmodule

// File: rtl/gpio_mux_port_chk.sv
// Module: property checker bound to the port top. It watches the register
// state, the pad drive and the synchronizer output.
module gpio_mux_port_chk #(
    parameter int unsigned PINS   = 16,
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [PINS-1:0]   bus_wdata,
    input logic [PINS-1:0]   bus_rdata,
    input logic [PINS-1:0]   pad_in,
    input logic [PINS-1:0]   pad_oe,
    input logic [PINS-1:0]   pad_out,
    input logic [PINS-1:0]   per_in,
    input logic [PINS-1:0]   assign_q,
    input logic [PINS-1:0]   dir_q,
    input logic [PINS-1:0]   odrain_q
);

    logic [1:0] since_rst;

    // Count edges since reset release, saturating, to guard history checks.
    always_ff @(posedge clk) begin
        if (!rst_n)                since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R2: an assignment write lands on the next edge.
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(32'h0)) |=> (assign_q == $past(bus_wdata)));

    // R3: software inputs never drive.
    p_sw_in_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((~assign_q & ~dir_q & pad_oe) == '0));

    // R5: an open-drain pin never drives a high.
    p_odrain_no_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((odrain_q & pad_out) == '0));

    // R8: peripheral inputs never drive.
    p_per_in_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((assign_q & ~dir_q & pad_oe) == '0));

    // R9: the peripheral sees the pad two edges late.
    p_sync_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (per_in == $past(pad_in, 2)));

    // R10: the data offset reads the pad path, not the latch.
    p_data_read_pad_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(32'hC)) |-> (bus_rdata == per_in));

endmodule

bind gpio_mux_port gpio_mux_port_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .per_in    (per_in),
    .assign_q  (assign_q),
    .dir_q     (dir_q),
    .odrain_q  (odrain_q)
);

// File: tb/gpio_mux_port_bench.sv
// Directed bench for the multiplexed pin port: one task per scenario.
module gpio_mux_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_oe;
    logic [15:0] pad_out;
    logic [15:0] per_out = '0;
    logic [15:0] per_oe = '0;
    logic [15:0] per_in;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    gpio_mux_port u_gpio_mux_port (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .per_out(per_out),
        .per_oe(per_oe), .per_in(per_in)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        check("R1 oe after reset", pad_oe, 16'h0000);
        rd(4'h0, v); check("R1 assign", v, 16'h0);
        rd(4'h4, v); check("R1 dir", v, 16'h0);
        rd(4'h8, v); check("R1 odrain", v, 16'h0);
    endtask

    task automatic t_regs;
        logic [15:0] v;
        wr(4'h0, 16'hA5A5); rd(4'h0, v); check("R2 assign rw", v, 16'hA5A5);
        wr(4'h4, 16'h3C3C); rd(4'h4, v); check("R2 dir rw", v, 16'h3C3C);
        wr(4'h8, 16'h0FF0); rd(4'h8, v); check("R2 odrain rw", v, 16'h0FF0);
        wr(4'h2, 16'hFFFF); rd(4'h2, v); check("R2 unmapped reads 0", v, 16'h0);
        rd(4'h0, v); check("R2 unmapped write ignored", v, 16'hA5A5);
        wr(4'h0, 16'h0); wr(4'h4, 16'h0); wr(4'h8, 16'h0);
    endtask

    task automatic t_sw_modes;
        logic [15:0] v;
        per_oe = 16'hFFFF; per_out = 16'hFFFF;
        wr(4'hC, 16'h1234);
        check("R3 sw input quiet", pad_oe, 16'h0);
        wr(4'h4, 16'hFFFF);
        check("R4 sw out oe", pad_oe, 16'hFFFF);
        check("R4 sw out value", pad_out, 16'h1234);
        wr(4'h8, 16'hFFFF);
        check("R5 odrain oe", pad_oe, 16'hEDCB);
        check("R5 odrain value", pad_out, 16'h0);
        wr(4'h8, 16'h0);
        pad_in = 16'h5555;
        repeat (2) @(negedge clk);
        rd(4'hC, v); check("R10 read pad not latch", v, 16'h5555);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 4'hC; bus_wdata = 16'h00FF;
        #1; check("R10 read during write", bus_rdata, 16'h5555);
        @(negedge clk); bus_we = 1'b0; #1;
        check("R10 read after write", bus_rdata, 16'h5555);
        check("R4 new latch driven", pad_out, 16'h00FF);
    endtask

    task automatic t_periph;
        per_out = 16'h0F0F; per_oe = 16'h00FF;
        wr(4'h0, 16'hFFFF);
        wr(4'hC, 16'hFFFF);
        check("R6 periph oe", pad_oe, 16'h00FF);
        check("R6 periph value", pad_out, 16'h000F);
        wr(4'h8, 16'hFFFF);
        check("R7 periph odrain oe", pad_oe, 16'h00F0);
        check("R7 periph odrain value", pad_out, 16'h0);
        wr(4'h8, 16'h0);
        wr(4'h0, 16'h0);
        check("R11 latch written under periph", pad_out, 16'hFFFF);
        wr(4'h0, 16'hFFFF); wr(4'h4, 16'h0);
        per_oe = 16'hFFFF; #1;
        check("R8 periph input quiet", pad_oe, 16'h0);
    endtask

    task automatic t_sync;
        @(negedge clk); pad_in = 16'hBEEF;
        @(negedge clk); check("R9 one edge not yet", per_in, 16'h5555);
        @(negedge clk); check("R9 two edges", per_in, 16'hBEEF);
    endtask

    task automatic t_mixed_same_cycle;
        wr(4'h0, 16'h0);
        wr(4'h4, 16'h0FF0);
        wr(4'h8, 16'h0F00);
        wr(4'hC, 16'hFFFF);
        per_oe = 16'hFFFF; per_out = 16'h0000;
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 4'h0; bus_wdata = 16'h00F0; per_out = 16'h00A0;
        @(negedge clk); bus_we = 1'b0; #1;
        check("R12 mixed oe", pad_oe, 16'h00F0);
        check("R12 mixed value", pad_out, 16'h00A0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_regs();
        t_sw_modes();
        t_periph();
        t_sync();
        t_mixed_same_cycle();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule